// File: doc/BRIEF.md
# Step-Delayed Shared Variable Bank

This block holds a small set of shared variables for a group of parallel reactive state machines that run on a two-level time base. A coarse strobe (`tock`) opens each super-step; this is the only point where values from outside may be loaded. A fine strobe (`step`) closes each small step; this is the only point where writes made by the machines take effect. During a step, every machine sees the values committed at the previous boundary. Assignments such as `a := 2` and `b := a + 1` can therefore sit in the same step without ambiguity.

Machines present writes on several parallel ports. Each port has a valid bit, a variable index and a data byte. The writes collect in a pending buffer until the step strobe commits them together. At the commit, each variable gets a flag that says whether its value changed. Two writes to one variable inside the same step are a race. A value above a variable's ceiling is a range violation. Each of these conditions sets a sticky error flag. Each variable's ceiling is captured from a configuration input while reset is held.

Top module: `stepVarBank`

## Requirements
- R1: A write presented without `step` is not visible on `varValues` in any later cycle until a `step` cycle commits it. The committed values change only in a cycle with `step` or `tock`.
- R2: A second accepted write to a variable already written in the same step sets `raceErr` one cycle later. The second write can come from an earlier cycle of the step or from a higher-numbered port in the same cycle. The first accepted value is the one committed.
- R3: Writes to different variables in one step all commit together at `step`. Writes presented in the `step` cycle itself belong to the step that is closing. A value computed from `varValues` during the step uses the old committed value.
- R4: After a `step`, `changed[i]` is 1 exactly when variable i was written in that step with a value different from its previous committed value. After a load by `tock`, `changed[i]` is 1 exactly when variable i was loaded with a different value. In all other cycles `changed` holds.
- R5: Variable i has the ceiling `maxInit[8i+7:8i]`, captured during reset. A port write or external load whose data is above the ceiling of its variable sets `rangeErr` one cycle later and is discarded. Committed values never exceed their ceilings.
- R6: `raceErr` and `rangeErr` stay set until a cycle with `errClear`. If a new error arrives in the clear cycle, the flag stays set.
- R7: `extLoadData[8i+7:8i]` is loaded into variable i only in a cycle with `tock` high, `step` low and `extLoadEn[i]` high. In every other cycle the external inputs have no effect.
- R8: After reset, all values are 0, `changed` is 0, both error flags are 0 and no write is pending.
- R9: A `step` clears the pending buffer. A following `step` with no writes leaves every value unchanged and `changed` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; ceilings are captured while low |
| maxInit | input | NUM_VARS*DATA_W | Per-variable ceiling, variable i in bits 8i+7:8i |
| tock | input | 1 | Super-step strobe, external load point |
| step | input | 1 | Small-step strobe, commit point |
| extLoadEn | input | NUM_VARS | Per-variable external load enable |
| extLoadData | input | NUM_VARS*DATA_W | External load values |
| wrValid | input | NUM_PORTS | Write port valid bits |
| wrIdx | input | NUM_PORTS*IDX_W | Write port variable index, port p in bits 3p+2:3p |
| wrData | input | NUM_PORTS*DATA_W | Write port data, port p in bits 8p+7:8p |
| errClear | input | 1 | Clears the sticky error flags |
| varValues | output | NUM_VARS*DATA_W | Committed values, variable i in bits 8i+7:8i |
| changed | output | NUM_VARS | Per-variable changed flags |
| raceErr | output | 1 | Sticky race flag |
| rangeErr | output | 1 | Sticky out-of-range flag |

## Verification
A pending entry that leaks early shows up on `varValues` in the cycle after the write, one cycle before the step that should commit it. A pending entry that fails to clear shows up as a race or a spurious `changed` bit at the next commit. A wrong merge order between ports commits the later value instead of the earlier one, which is visible right after the step edge. Ceiling or error-flag faults appear as a missing or stuck `rangeErr` or `raceErr` one cycle after the offending write.

// File: rtl/stepVarPkg.sv
package stepVarPkg;
  typedef struct packed {
    logic commit;
    logic load;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/stepVarCtrl.sv
module stepVarCtrl
  import stepVarPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    step,
  input  logic    tock,
  input  logic    errClear,
  input  logic    raceHit,
  input  logic    rangeHit,
  output strobe_t strobes,
  output logic    raceErr,
  output logic    rangeErr
);
  always_comb begin
    strobes.commit = step;
    strobes.load   = tock & ~step;
    strobes.clear  = errClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      raceErr  <= 1'b0;
      rangeErr <= 1'b0;
    end else begin
      if (raceHit)       raceErr <= 1'b1;
      else if (errClear) raceErr <= 1'b0;
      if (rangeHit)       rangeErr <= 1'b1;
      else if (errClear)  rangeErr <= 1'b0;
    end
  end

  AST_RACE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    raceHit |=> raceErr); // R2
  AST_RANGE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    rangeHit |=> rangeErr); // R5
  AST_RACE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (raceErr && !errClear) |=> raceErr); // R6
  AST_RANGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rangeErr && !errClear) |=> rangeErr); // R6
endmodule

// File: rtl/stepVarDatapath.sv
module stepVarDatapath
  import stepVarPkg::*;
#(
  parameter int NUM_VARS  = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 4,
  localparam int IDX_W    = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobes,
  input  logic [NUM_VARS*DATA_W-1:0]    maxInit,
  input  logic [NUM_VARS-1:0]           extLoadEn,
  input  logic [NUM_VARS*DATA_W-1:0]    extLoadData,
  input  logic [NUM_PORTS-1:0]          wrValid,
  input  logic [NUM_PORTS*IDX_W-1:0]    wrIdx,
  input  logic [NUM_PORTS*DATA_W-1:0]   wrData,
  output logic [NUM_VARS*DATA_W-1:0]    varValues,
  output logic [NUM_VARS-1:0]           changed,
  output logic                          raceHit,
  output logic                          rangeHit
);
  logic [DATA_W-1:0] vals     [NUM_VARS];
  logic [DATA_W-1:0] maxReg   [NUM_VARS];
  logic [DATA_W-1:0] pendData [NUM_VARS];
  logic [DATA_W-1:0] nextData [NUM_VARS];
  logic [NUM_VARS-1:0] pendValid;
  logic [NUM_VARS-1:0] nextValid;
  logic [NUM_VARS-1:0] loadOk;

  // Merge this cycle's port writes into the pending buffer, lowest port first.
  always_comb begin
    logic [IDX_W-1:0]  pIdx;
    logic [DATA_W-1:0] pData;
    nextValid = pendValid;
    nextData  = pendData;
    raceHit   = 1'b0;
    rangeHit  = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      pIdx  = wrIdx[p*IDX_W +: IDX_W];
      pData = wrData[p*DATA_W +: DATA_W];
      if (wrValid[p]) begin
        if (int'(pIdx) >= NUM_VARS) begin
          rangeHit = 1'b1;
        end else if (pData > maxReg[pIdx]) begin
          rangeHit = 1'b1;
        end else if (nextValid[pIdx]) begin
          raceHit = 1'b1;
        end else begin
          nextValid[pIdx] = 1'b1;
          nextData[pIdx]  = pData;
        end
      end
    end
    for (int i = 0; i < NUM_VARS; i++) begin
      loadOk[i] = strobes.load && extLoadEn[i] &&
                  (extLoadData[i*DATA_W +: DATA_W] <= maxReg[i]);
      if (strobes.load && extLoadEn[i] &&
          (extLoadData[i*DATA_W +: DATA_W] > maxReg[i]))
        rangeHit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VARS; i++) begin
        vals[i]     <= '0;
        pendData[i] <= '0;
        maxReg[i]   <= maxInit[i*DATA_W +: DATA_W];
      end
      pendValid <= '0;
      changed   <= '0;
    end else if (strobes.commit) begin
      for (int i = 0; i < NUM_VARS; i++) begin
        if (nextValid[i]) vals[i] <= nextData[i];
        changed[i] <= nextValid[i] && (nextData[i] != vals[i]);
      end
      pendValid <= '0;
    end else begin
      pendValid <= nextValid;
      pendData  <= nextData;
      if (strobes.load) begin
        for (int i = 0; i < NUM_VARS; i++) begin
          if (loadOk[i]) vals[i] <= extLoadData[i*DATA_W +: DATA_W];
          changed[i] <= loadOk[i] && (extLoadData[i*DATA_W +: DATA_W] != vals[i]);
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_VARS; g++) begin : g_flat
    assign varValues[g*DATA_W +: DATA_W] = vals[g];
    AST_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rstN)
      vals[g] <= maxReg[g]); // R5
  end

  AST_VALUES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.commit && !strobes.load) |=> $stable(varValues)); // R1
  AST_CHANGED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.commit && !strobes.load) |=> $stable(changed)); // R4
  AST_QUIET_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && nextValid == '0) |=> (changed == '0 && $stable(varValues))); // R9
endmodule

// File: rtl/stepVarBank.sv
module stepVarBank
  import stepVarPkg::*;
#(
  parameter int NUM_VARS  = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 4,
  localparam int IDX_W    = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_VARS*DATA_W-1:0]  maxInit,
  input  logic                        tock,
  input  logic                        step,
  input  logic [NUM_VARS-1:0]         extLoadEn,
  input  logic [NUM_VARS*DATA_W-1:0]  extLoadData,
  input  logic [NUM_PORTS-1:0]        wrValid,
  input  logic [NUM_PORTS*IDX_W-1:0]  wrIdx,
  input  logic [NUM_PORTS*DATA_W-1:0] wrData,
  input  logic                        errClear,
  output logic [NUM_VARS*DATA_W-1:0]  varValues,
  output logic [NUM_VARS-1:0]         changed,
  output logic                        raceErr,
  output logic                        rangeErr
);
  strobe_t strobes;
  logic    raceHit;
  logic    rangeHit;

  stepVarCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .step(step), .tock(tock), .errClear(errClear),
    .raceHit(raceHit), .rangeHit(rangeHit), .strobes(strobes),
    .raceErr(raceErr), .rangeErr(rangeErr)
  );

  stepVarDatapath #(
    .NUM_VARS(NUM_VARS), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .maxInit(maxInit),
    .extLoadEn(extLoadEn), .extLoadData(extLoadData),
    .wrValid(wrValid), .wrIdx(wrIdx), .wrData(wrData),
    .varValues(varValues), .changed(changed),
    .raceHit(raceHit), .rangeHit(rangeHit)
  );
endmodule

// File: tb/stepVarBank_tb.sv
module stepVarBank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] maxInit;
  logic        tock, step, errClear;
  logic [7:0]  extLoadEn;
  logic [63:0] extLoadData;
  logic [3:0]  wrValid;
  logic [11:0] wrIdx;
  logic [31:0] wrData;
  logic [63:0] varValues;
  logic [7:0]  changed;
  logic        raceErr, rangeErr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepVarBank dut_i (
    .clk(clk), .rstN(rstN), .maxInit(maxInit), .tock(tock), .step(step),
    .extLoadEn(extLoadEn), .extLoadData(extLoadData), .wrValid(wrValid),
    .wrIdx(wrIdx), .wrData(wrData), .errClear(errClear),
    .varValues(varValues), .changed(changed), .raceErr(raceErr), .rangeErr(rangeErr)
  );

  typedef struct packed {
    logic [3:0]  v;
    logic [11:0] idx;
    logic [31:0] dat;
    logic [2:0]  chkIdx;
    logic [7:0]  expVal;
    logic        expChg;
    logic        expRace;
  } vec_t;

  // Each vector is presented together with step; the ceiling of variable 7 is 0x0F.
  localparam vec_t VECS [7] = '{
    '{4'b0001, {3'd0,3'd0,3'd0,3'd1}, 32'h0000_0001, 3'd1, 8'h01, 1'b1, 1'b0},
    '{4'b0011, {3'd0,3'd0,3'd3,3'd2}, 32'h0000_0605, 3'd3, 8'h06, 1'b1, 1'b0},
    '{4'b0001, {3'd0,3'd0,3'd0,3'd1}, 32'h0000_0001, 3'd1, 8'h01, 1'b0, 1'b0},
    '{4'b0101, {3'd0,3'd4,3'd0,3'd4}, 32'h0003_0009, 3'd4, 8'h09, 1'b1, 1'b1},
    '{4'b1000, {3'd7,3'd0,3'd0,3'd0}, 32'h0E00_0000, 3'd7, 8'h0E, 1'b1, 1'b0},
    '{4'b1110, {3'd0,3'd6,3'd5,3'd0}, 32'hFF81_8000, 3'd0, 8'hFF, 1'b1, 1'b0},
    '{4'b0000, 12'd0,                 32'h0000_0000, 3'd0, 8'hFF, 1'b0, 1'b0}
  };

  function automatic logic [7:0] getVar(input int i);
    return varValues[i*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    tock = 0; step = 0; errClear = 0; extLoadEn = '0; extLoadData = '0;
    wrValid = '0; wrIdx = '0; wrData = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr1(input int idx, input logic [7:0] d);
    wrValid = 4'b0001; wrIdx = 12'(idx); wrData = {24'd0, d};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog act=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] oldV1;
    idleInputs();
    maxInit = {8'h0F, {7{8'hFF}}};
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    tick();
    check("R8 values", varValues, 64'd0);
    check("R8 changed", {56'd0, changed}, 64'd0);
    check("R8 errors", {62'd0, raceErr, rangeErr}, 64'd0);

    // Table walk
    foreach (VECS[k]) begin
      wrValid = VECS[k].v; wrIdx = VECS[k].idx; wrData = VECS[k].dat; step = 1;
      tick();
      check("R3 table value", {56'd0, getVar(int'(VECS[k].chkIdx))}, {56'd0, VECS[k].expVal});
      check("R4 table changed", {63'd0, changed[VECS[k].chkIdx]}, {63'd0, VECS[k].expChg});
      check("R2 table race", {63'd0, raceErr}, {63'd0, VECS[k].expRace});
      idleInputs(); errClear = 1;
      tick();
      idleInputs();
    end
    check("R3 table state", varValues, 64'h0E81_8009_0605_01FF);

    // R1: write without step stays invisible
    wr1(1, 8'h02);
    tick(); idleInputs();
    check("R1 hidden write", {56'd0, getVar(1)}, 64'h01);
    // R3: v2 := v1 + 1 computed from the old v1, committed with v1 := 2
    oldV1 = getVar(1);
    wr1(2, oldV1 + 8'd1); step = 1;
    tick(); idleInputs();
    check("R3 v1 committed", {56'd0, getVar(1)}, 64'h02);
    check("R3 v2 from old v1", {56'd0, getVar(2)}, 64'h02);
    check("R3 no race", {63'd0, raceErr}, 64'd0);
    check("R4 changed after step", {56'd0, changed}, 64'h06);
    tick();
    check("R4 changed held", {56'd0, changed}, 64'h06);
    // R9: empty step
    step = 1; tick(); idleInputs();
    check("R9 empty step changed", {56'd0, changed}, 64'h00);
    check("R9 empty step values", {56'd0, getVar(1)}, 64'h02);

    // R2: race across cycles of one step, first value kept
    wr1(3, 8'h07); tick(); idleInputs();
    wr1(3, 8'h08); step = 1; tick(); idleInputs();
    check("R2 race flag", {63'd0, raceErr}, 64'd1);
    check("R2 first value kept", {56'd0, getVar(3)}, 64'h07);
    tick();
    check("R6 race sticky", {63'd0, raceErr}, 64'd1);
    errClear = 1; tick(); idleInputs();
    check("R6 race cleared", {63'd0, raceErr}, 64'd0);

    // R5: out-of-range write discarded
    wr1(7, 8'h10); step = 1; tick(); idleInputs();
    check("R5 range flag", {63'd0, rangeErr}, 64'd1);
    check("R5 value kept", {56'd0, getVar(7)}, 64'h0E);
    check("R5 no change", {63'd0, changed[7]}, 64'd0);
    // R6: new error in the clear cycle wins
    errClear = 1; wr1(7, 8'h20); tick(); idleInputs();
    check("R6 set beats clear", {63'd0, rangeErr}, 64'd1);
    errClear = 1; tick(); idleInputs();
    check("R6 range cleared", {63'd0, rangeErr}, 64'd0);

    // R7: external loads
    extLoadEn = 8'h04; extLoadData = 64'h0000_0000_0033_0000; tick(); idleInputs();
    check("R7 load without tock", {56'd0, getVar(2)}, 64'h02);
    extLoadEn = 8'h04; extLoadData = 64'h0000_0000_0033_0000; tock = 1; tick(); idleInputs();
    check("R7 load on tock", {56'd0, getVar(2)}, 64'h33);
    check("R4 changed after load", {56'd0, changed}, 64'h04);
    extLoadEn = 8'h04; extLoadData = 64'h0000_0000_0044_0000; tock = 1; step = 1;
    tick(); idleInputs();
    check("R7 tock with step ignored", {56'd0, getVar(2)}, 64'h33);
    check("R4 changed after empty step", {56'd0, changed}, 64'h00);
    extLoadEn = 8'h80; extLoadData = 64'h2000_0000_0000_0000; tock = 1; tick(); idleInputs();
    check("R5 load out of range flag", {63'd0, rangeErr}, 64'd1);
    check("R5 load out of range kept", {56'd0, getVar(7)}, 64'h0E);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule